// File: doc/BRIEF.md
# I2C Register Target with Normal and Setup Modes

This block is an I2C target that gives a bus master access to 256 internal 8-bit registers. The master opens every transfer with an address byte. The target answers only when the upper seven bits of that byte match its own address, which is held in a register of the map. A write transfer sends a register pointer and then data bytes. A read transfer returns bytes starting at the pointer. After each received byte the target holds SCL low until internal processing of that byte has finished. The end of processing needs both a done strobe from the surrounding logic and a minimum latency counter.

The mode flag chooses between normal and setup operation. In normal mode a fixed group of registers refuses writes. In setup mode every register can be written, but processing takes longer, unless the scanning activity has been switched off through the command register. A mode change written over the bus takes effect only at the next STOP.

Top module: `i2c_regslave`

## Requirements
- R1: The first byte after a START holds the target address in bits 7..1 and the direction in bit 0 (0 = master writes, 1 = master reads). On a match the target pulls SDA low during the ninth clock (ACK). On a mismatch SDA stays released (NAK), SCL is never held low, and the target ignores the bus until the next START.
- R2: After the eighth bit of every byte the target receives with a matching address, it drives SCL low from the following SCL falling edge. `proc_busy` is high for exactly as long as SCL is held. SCL stays held until `proc_done` has been seen and the latency counter has expired.
- R3: In a write transfer the byte after the address loads the register pointer. Each following data byte is written at the pointer, and the pointer then increments. A read transfer returns the register at the pointer, increments the pointer for each byte sent, and ends when the master answers NAK.
- R4: While `setup_mode` is 0, writes to registers 0x07, 0x08, 0x11, 0x50, 0x51, 0x5C and 0x5D are acknowledged and discarded. All other registers take writes normally.
- R5: While `setup_mode` is 1, every register, including the protected group, stores written data.
- R6: Bit 0 of register 0xA1 selects the mode (1 = setup). A write to it changes `setup_mode` only when the next STOP condition is detected.
- R7: Writing code 0x0A to command register 0xA0 clears `scan_en`. Only reset sets it again.
- R8: The latency counter load is LAT_NORM in normal mode. In setup mode it is LAT_SETUP while `scan_en` is 1 and LAT_NOSCAN once scanning is off.
- R9: Bits 6..0 of register 0xB0 are the target address. A new value applies to every later address byte.
- R10: A START or STOP detected at any point, including in the middle of a byte, resets bit counting and the transfer phase.
- R11: After reset both open-drain enables are released, `proc_busy` is 0, `setup_mode` is 0, `scan_en` is 1, and every register, including the address, is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock hold) |
| sda_oe | output | 1 | 1 pulls SDA low |
| proc_busy | output | 1 | Byte processing in progress; SCL held |
| proc_done | input | 1 | Strobe from internal logic: processing finished |
| setup_mode | output | 1 | 1 = setup mode, 0 = normal mode |
| scan_en | output | 1 | Scanning activity enabled |

## Verification
The assertions assume a master that changes SDA only while SCL is low, except when it makes START and STOP. They also assume that the master keeps SCL and SDA high for several clocks around a STOP, so that the mode change sits inside that window. The bench master drives both lines open-drain, with half-periods of ten clocks. It waits for SCL to read high before it continues, so a held clock always stalls it. The one exception to the SDA rule is a deliberate START inside a byte, and the bench issues it only while the target is receiving and not driving SDA.

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int LAT_NORM   = 4,
  parameter int LAT_SETUP  = 40,
  parameter int LAT_NOSCAN = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe,
  output logic sda_oe,
  output logic proc_busy,
  input  logic proc_done,
  output logic setup_mode,
  output logic scan_en
);
  localparam int CW = $clog2(LAT_NORM + LAT_SETUP + LAT_NOSCAN + 2);
  localparam logic [7:0] REG_CMD  = 8'hA0;
  localparam logic [7:0] REG_MODE = 8'hA1;
  localparam logic [7:0] REG_ADDR = 8'hB0;
  localparam logic [7:0] CMD_SCAN_OFF = 8'h0A;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_STR, S_ACK, S_TX, S_RACK} st_t;

  st_t st;
  logic [2:0] scl_sy, sda_sy;
  logic [7:0] regs [0:255];
  logic [7:0] ptr, sh, tx;
  logic [3:0] bcnt;
  logic [1:0] phase;
  logic rw, mack, dseen;
  logic [CW-1:0] cnt;

  wire scl   = scl_sy[1];
  wire sda   = sda_sy[1];
  wire scl_p = scl_sy[2];
  wire sda_p = sda_sy[2];
  wire start = scl & scl_p & sda_p & ~sda;
  wire stop  = scl & scl_p & ~sda_p & sda;
  wire rise  = scl & ~scl_p;
  wire fall  = ~scl & scl_p;

  wire [6:0] own = regs[REG_ADDR][6:0];
  wire [CW-1:0] lat = !setup_mode ? CW'(LAT_NORM) :
                      scan_en ? CW'(LAT_SETUP) : CW'(LAT_NOSCAN);

  function automatic logic prot(input logic [7:0] a);
    return a inside {8'h07, 8'h08, 8'h11, 8'h50, 8'h51, 8'h5C, 8'h5D};
  endfunction

  assign proc_busy = (st == S_STR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 3'b111;
      sda_sy <= 3'b111;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < 256; i++) regs[i] <= 8'h00;
      ptr <= '0; sh <= '0; tx <= '0; bcnt <= '0; phase <= '0;
      rw <= 1'b0; mack <= 1'b0; dseen <= 1'b0; cnt <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      setup_mode <= 1'b0; scan_en <= 1'b1;
    end else if (start) begin
      st <= S_RX; bcnt <= '0; phase <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; bcnt <= '0; phase <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      setup_mode <= regs[REG_MODE][0];
    end else begin
      case (st)
        S_RX: begin
          if (rise) begin
            sh <= {sh[6:0], sda};
            bcnt <= bcnt + 4'd1;
          end else if (fall && bcnt == 4'd8) begin
            bcnt <= '0;
            if (phase == 2'd0) begin
              if (sh[7:1] == own) begin
                rw <= sh[0]; phase <= 2'd1;
                sda_oe <= 1'b1; scl_oe <= 1'b1;
                cnt <= lat; dseen <= 1'b0; st <= S_STR;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              if (phase == 2'd1) begin
                ptr <= sh; phase <= 2'd2;
              end else begin
                if (setup_mode || !prot(ptr)) regs[ptr] <= sh;
                if (ptr == REG_CMD && sh == CMD_SCAN_OFF) scan_en <= 1'b0;
                ptr <= ptr + 8'd1;
              end
              sda_oe <= 1'b1; scl_oe <= 1'b1;
              cnt <= lat; dseen <= 1'b0; st <= S_STR;
            end
          end
        end
        S_STR: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          if (proc_done) dseen <= 1'b1;
          if (cnt == '0 && (dseen || proc_done)) begin
            scl_oe <= 1'b0; st <= S_ACK;
          end
        end
        S_ACK: begin
          if (fall) begin
            if (rw) begin
              tx <= regs[ptr]; sda_oe <= ~regs[ptr][7];
              ptr <= ptr + 8'd1; bcnt <= '0; st <= S_TX;
            end else begin
              sda_oe <= 1'b0; st <= S_RX;
            end
          end
        end
        S_TX: begin
          if (fall) begin
            if (bcnt == 4'd7) begin
              sda_oe <= 1'b0; st <= S_RACK;
            end else begin
              sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0};
            end
            bcnt <= bcnt + 4'd1;
          end
        end
        S_RACK: begin
          if (rise) mack <= ~sda;
          else if (fall) begin
            if (mack) begin
              tx <= regs[ptr]; sda_oe <= ~regs[ptr][7];
              ptr <= ptr + 8'd1; bcnt <= '0; st <= S_TX;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic scl_oe,
  input logic sda_oe,
  input logic proc_busy,
  input logic proc_done,
  input logic setup_mode,
  input logic scan_en
);
  logic dflag;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dflag <= 1'b0;
    else if (!proc_busy) dflag <= 1'b0;
    else if (proc_done) dflag <= 1'b1;
  end

  a_r2_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> dflag);

  a_r2_hold_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_i);

  a_r1_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  a_r6_mode_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(setup_mode) |-> (scl_i && sda_i));

  a_r7_scan_never_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(scan_en));
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (.*);

// File: tb/sim_i2c_regslave.sv
module sim_i2c_regslave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl_oe, sda_oe, proc_busy, setup_mode, scan_en;
  logic done_q = 1'b0, hold = 1'b0;
  wire scl_line = m_scl & ~scl_oe;
  wire sda_line = m_sda & ~sda_oe;
  wire proc_done = done_q & ~hold;

  int checks = 0, failures = 0, run = 0, last_str = 0, oe_total = 0;
  logic [6:0] cur = 7'h00;
  bit finished = 0;

  always #5 clk = ~clk;

  i2c_regslave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .proc_busy(proc_busy), .proc_done(proc_done),
    .setup_mode(setup_mode), .scan_en(scan_en));

  always @(posedge clk) begin
    done_q <= proc_busy;
    if (scl_oe) begin run <= run + 1; oe_total <= oe_total + 1; end
    else if (run != 0) begin last_str <= run; run <= 0; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic i_start();
    m_sda = 1; wt(10); m_scl = 1; wt(10); m_sda = 0; wt(10); m_scl = 0; wt(10);
  endtask
  task automatic i_stop();
    m_sda = 0; wt(10); m_scl = 1;
    while (!scl_line) wt(1);
    wt(10); m_sda = 1; wt(20);
  endtask
  task automatic bit_w(input logic b);
    m_sda = b; wt(10); m_scl = 1;
    while (!scl_line) wt(1);
    wt(10); m_scl = 0; wt(1);
  endtask
  task automatic bit_r(output logic b);
    m_sda = 1; wt(10); m_scl = 1;
    while (!scl_line) wt(1);
    wt(5); b = sda_line; wt(5); m_scl = 0; wt(1);
  endtask
  task automatic byte_w(input logic [7:0] d, output logic nak);
    for (int i = 7; i >= 0; i--) bit_w(d[i]);
    bit_r(nak);
  endtask
  task automatic byte_r(input logic ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) bit_r(d[i]);
    bit_w(~ack);
  endtask

  task automatic wr(input logic [7:0] r, input logic [7:0] d);
    logic n;
    i_start(); byte_w({cur, 1'b0}, n); byte_w(r, n); byte_w(d, n); i_stop();
  endtask
  task automatic rd(input logic [7:0] r, output logic [7:0] d, output logic n);
    logic x;
    i_start(); byte_w({cur, 1'b0}, n); byte_w(r, x);
    i_start(); byte_w({cur, 1'b1}, x); byte_r(1'b0, d); i_stop();
  endtask

  localparam logic [23:0] VEC [10] = '{
    {8'h10, 8'h5A, 8'h5A}, {8'h07, 8'h33, 8'h00}, {8'h08, 8'hC3, 8'h00},
    {8'h11, 8'hFF, 8'h00}, {8'h50, 8'h81, 8'h00}, {8'h51, 8'h7E, 8'h00},
    {8'h5C, 8'h11, 8'h00}, {8'h5D, 8'h22, 8'h00}, {8'h5B, 8'h44, 8'h44},
    {8'h12, 8'hA5, 8'hA5}};

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic n, n2;
    int base;
    wt(5); rst_n = 1; wt(5);
    chk(!scl_oe && !sda_oe && !proc_busy, "R11 released", {scl_oe, sda_oe, proc_busy}, 0);
    chk(!setup_mode && scan_en, "R11 mode/scan", {setup_mode, scan_en}, 1);
    rd(8'hB0, d, n);
    chk(!n && d == 8'h00, "R11 address 0x00", {n, d}, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], d, n);
      chk(d == VEC[i][7:0], "R4 R3 vector", d, VEC[i][7:0]);
    end
    chk(last_str >= 2 && last_str <= 8, "R8 normal latency", last_str, 5);

    base = oe_total;
    i_start(); byte_w(8'hA4, n); i_stop();
    chk(n == 1'b1, "R1 mismatch NAK", n, 1);
    chk(oe_total == base, "R1 no hold on mismatch", oe_total - base, 0);

    hold = 1;
    i_start();
    fork
      byte_w({cur, 1'b0}, n);
      begin
        while (!proc_busy) wt(1);
        wt(100);
        chk(scl_oe && !scl_line && proc_busy, "R2 hold until done", scl_oe, 1);
        hold = 0;
      end
    join
    i_stop();
    chk(n == 1'b0, "R1 match ACK", n, 0);
    chk(last_str >= 100, "R2 stretch length", last_str, 100);

    i_start(); byte_w({cur, 1'b0}, n); byte_w(8'h20, n);
    byte_w(8'h01, n); byte_w(8'h02, n); byte_w(8'h03, n); i_stop();
    i_start(); byte_w({cur, 1'b0}, n); byte_w(8'h20, n);
    i_start(); byte_w({cur, 1'b1}, n);
    byte_r(1'b1, d); chk(d == 8'h01, "R3 burst 0", d, 1);
    byte_r(1'b1, d); chk(d == 8'h02, "R3 burst 1", d, 2);
    byte_r(1'b0, d); chk(d == 8'h03, "R3 burst 2", d, 3);
    i_stop();

    i_start(); byte_w({cur, 1'b0}, n); bit_w(1); bit_w(1); bit_w(1);
    i_start(); byte_w({cur, 1'b0}, n); byte_w(8'h30, n2); byte_w(8'h77, n2); i_stop();
    chk(n == 1'b0, "R10 ack after restart", n, 0);
    rd(8'h30, d, n);
    chk(d == 8'h77, "R10 write after abort", d, 8'h77);

    i_start(); byte_w({cur, 1'b0}, n); byte_w(8'hA1, n); byte_w(8'h01, n);
    wt(20);
    chk(setup_mode == 1'b0, "R6 no change before STOP", setup_mode, 0);
    i_stop();
    chk(setup_mode == 1'b1, "R6 setup after STOP", setup_mode, 1);

    wr(8'h07, 8'h33);
    chk(last_str >= 40, "R8 setup latency", last_str, 41);
    rd(8'h07, d, n);
    chk(d == 8'h33, "R5 setup write protected reg", d, 8'h33);

    wr(8'hA0, 8'h0A);
    chk(scan_en == 1'b0, "R7 scan off", scan_en, 0);
    wr(8'h40, 8'h01);
    chk(last_str <= 10, "R8 setup no-scan latency", last_str, 7);

    wr(8'hB0, 8'h25);
    rd(8'h07, d, n);
    chk(n == 1'b1, "R9 old address NAK", n, 1);
    cur = 7'h25;
    rd(8'h07, d, n);
    chk(!n && d == 8'h33, "R9 new address", {n, d}, 8'h33);

    wr(8'hA1, 8'h00);
    chk(setup_mode == 1'b0, "R6 back to normal", setup_mode, 0);
    wr(8'h07, 8'h99);
    rd(8'h07, d, n);
    chk(d == 8'h33, "R4 protected again", d, 8'h33);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule